// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a 64-bit timer with a 32-bit register port that can be promoted into a watchdog. While disarmed it behaves as a general timer. Software loads the period and counter halves, releases both halves, and picks a run mode: off, run once or wrap. To turn it into a watchdog, software selects watchdog mode in the global control register. It then writes two 16-bit keys in a fixed order into the watchdog control register, each with the enable bit set.

Once armed, the configuration is frozen. The counter restarts from zero and climbs by one each clock. Software must write the same two keys again, in order, before the counter meets the period. If the counter meets the period, or software writes an out-of-order key, the block drives a one-cycle reset pulse and sets a sticky flag. Only the system reset takes the block out of watchdog operation.

Top module: `keyed_wdog_timer`

## Requirements
- R1: After reset, every register reads zero except the identification word, the block is disarmed, and `wdog_rst_o` is low.
- R2: Registers are decoded at byte offsets 0x00 (identification, reads parameter `ID_VALUE`), 0x10/0x14 (counter bits 31:0 / 63:32), 0x18/0x1C (period bits 31:0 / 63:32), 0x20 (run mode in bits 7:6, other bits read 0), 0x24 (control bits 3:0, other bits read 0) and 0x28 (watchdog control). Every other offset reads zero.
- R3: While disarmed, with bits 1:0 of 0x24 both set, the counter counts each clock for run mode 2 and returns to 0 on the clock after it equals the period. For run mode 1 it stops at the period. For run mode 0 it holds. `wdog_rst_o` never pulses while disarmed.
- R4: Arming takes two writes to 0x28 with bit 14 set: first key 0xA5C6 in bits 31:16, which only counts when bits 3:2 of 0x24 equal 2, and then key 0xDA7E. Arming clears the counter to zero. A first key without bit 14, or without that mode, leaves the block disarmed.
- R5: Bit 14 of 0x28 reads 1 from the accepted first key onward, and writing 0 to it does not clear it. The key field always reads 0.
- R6: From the accepted first key onward, writes to offsets 0x10 through 0x24 change nothing.
- R7: After the first key, any other nonzero key, or the second key without bit 14, returns the block to disarmed and lifts the write protection.
- R8: When armed, if the counter equals the period on a clock edge, `wdog_rst_o` is high for the following cycle, bit 15 of 0x28 sets, and the count restarts from 0. With period P the first pulse comes P+1 cycles after the arming write.
- R9: When armed, writing the first key and then the second key restarts the count from zero and produces no pulse.
- R10: When armed, a nonzero key that is not the one expected next gives an immediate reset pulse on the cycle after the write. It also sets the flag, restarts the count, and leaves the block waiting for the first key.
- R11: Writing 1 to bit 15 of 0x28 clears the flag in any state. A write whose key field is zero leaves the key sequence where it was.
- R12: Once armed, the block stays armed until the system reset `rst_n` is asserted, and that reset returns it to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that the write strobe and the key field are the only things that move the key sequence, and that the period is never zero while armed. The stimulus writes at most one register per clock and always programs a nonzero period before arming. Every bad key it sends is spaced at least one cycle from any other reset cause, so each pulse has a single reason. Random data is used only on registers whose expected readback is a mask of the written word, or on writes that protection must discard.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ST_DISARM  = 2'd0,
    ST_PRE     = 2'd1,
    ST_LIVE    = 2'd2,
    ST_LIVE_K1 = 2'd3
  } kwd_state_e;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_RUN    = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h24;
  localparam logic [7:0] OFS_WDOG   = 8'h28;

  localparam logic [1:0] RUN_OFF  = 2'd0;
  localparam logic [1:0] RUN_ONCE = 2'd1;
  localparam logic [1:0] MODE_WDOG = 2'd2;

  function automatic logic [15:0] key_of(input logic [REG_W-1:0] w);
    return w[31:16];
  endfunction

  function automatic logic enable_of(input logic [REG_W-1:0] w);
    return w[14];
  endfunction

  function automatic logic flag_clr_of(input logic [REG_W-1:0] w);
    return w[15];
  endfunction

  function automatic logic [REG_W-1:0] wdog_word(input logic flag, input logic armed);
    return {16'h0000, flag, armed, 14'h0000};
  endfunction
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [15:0] key,
  input  logic       en_bit,
  input  logic       mode_ok,
  output kwd_state_e state,
  output logic       arm_done,
  output logic       svc_done,
  output logic       bad_key
);
  kwd_state_e nxt;

  always_comb begin
    nxt      = state;
    arm_done = 1'b0;
    svc_done = 1'b0;
    bad_key  = 1'b0;
    if (key_wr && key != 16'h0000) begin
      case (state)
        ST_DISARM: if (key == KEY_FIRST && en_bit && mode_ok) nxt = ST_PRE;
        ST_PRE: begin
          if (key == KEY_SECOND && en_bit) begin
            nxt      = ST_LIVE;
            arm_done = 1'b1;
          end else begin
            nxt = ST_DISARM;
          end
        end
        ST_LIVE: begin
          if (key == KEY_FIRST) nxt = ST_LIVE_K1;
          else bad_key = 1'b1;
        end
        default: begin
          nxt = ST_LIVE;
          if (key == KEY_SECOND) svc_done = 1'b1;
          else bad_key = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_DISARM;
    else        state <= nxt;
  end
endmodule

// File: rtl/kwd_cfg.sv
module kwd_cfg
  import kwd_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic [1:0]    wr_prd,
  input  logic          wr_run,
  input  logic          wr_ctrl,
  input  logic [HW-1:0] wdata,
  output logic [2*HW-1:0] period,
  output logic [1:0]    run_mode,
  output logic [3:0]    ctrl
);
  logic [HW-1:0] prd_half [2];

  for (genvar g = 0; g < 2; g++) begin : g_prd
    always_ff @(posedge clk) begin
      if (!rst_n)                    prd_half[g] <= '0;
      else if (wr_prd[g] && !locked) prd_half[g] <= wdata;
    end
    assign period[g*HW +: HW] = prd_half[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_mode <= RUN_OFF;
      ctrl     <= 4'h0;
    end else if (!locked) begin
      if (wr_run)  run_mode <= wdata[7:6];
      if (wr_ctrl) ctrl     <= wdata[3:0];
    end
  end
endmodule

// File: rtl/kwd_count.sv
module kwd_count
  import kwd_pkg::*;
#(
  parameter int HW = 32,
  localparam int W = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          live,
  input  logic          load_ok,
  input  logic [1:0]    wr_half,
  input  logic [HW-1:0] wdata,
  input  logic          gen_run,
  input  logic [1:0]    run_mode,
  input  logic [W-1:0]  period,
  output logic [W-1:0]  count,
  output logic          reached
);
  assign reached = (count == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (live) begin
      count <= count + 1'b1;
    end else if (load_ok && (|wr_half)) begin
      for (int h = 0; h < 2; h++)
        if (wr_half[h]) count[h*HW +: HW] <= wdata;
    end else if (gen_run) begin
      if (!reached)                 count <= count + 1'b1;
      else if (run_mode != RUN_ONCE) count <= '0;
    end
  end
endmodule

// File: rtl/keyed_wdog_timer.sv
module keyed_wdog_timer
  import kwd_pkg::*;
#(
  parameter int          AW       = 6,
  parameter logic [31:0] ID_VALUE = 32'h4B57_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          wdog_rst_o
);
  localparam int HW = REG_W;
  localparam int CW = 2 * HW;

  function automatic logic hit(input logic we, input logic [AW-1:0] a, input logic [7:0] ofs);
    return we && (a == AW'(ofs));
  endfunction

  logic wr_cnt_lo, wr_cnt_hi, wr_prd_lo, wr_prd_hi, wr_run, wr_ctrl, wr_wdog;
  assign wr_cnt_lo = hit(bus_we, bus_addr, OFS_CNT_LO);
  assign wr_cnt_hi = hit(bus_we, bus_addr, OFS_CNT_HI);
  assign wr_prd_lo = hit(bus_we, bus_addr, OFS_PRD_LO);
  assign wr_prd_hi = hit(bus_we, bus_addr, OFS_PRD_HI);
  assign wr_run    = hit(bus_we, bus_addr, OFS_RUN);
  assign wr_ctrl   = hit(bus_we, bus_addr, OFS_CTRL);
  assign wr_wdog   = hit(bus_we, bus_addr, OFS_WDOG);

  kwd_state_e    state;
  logic          arm_done, svc_done, bad_key;
  logic [CW-1:0] period, count;
  logic [1:0]    run_mode;
  logic [3:0]    ctrl;
  logic          reached, flag_q, fire;

  logic locked, live, gen_run, wr_prd_any;
  assign locked     = (state != ST_DISARM);
  assign live       = (state == ST_LIVE) || (state == ST_LIVE_K1);
  assign gen_run    = !locked && (ctrl[1:0] == 2'b11) && (run_mode != RUN_OFF);
  assign fire       = (live && reached) || bad_key;
  assign wr_prd_any = wr_prd_lo || wr_prd_hi;

  kwd_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_wdog),
    .key      (key_of(bus_wdata)),
    .en_bit   (enable_of(bus_wdata)),
    .mode_ok  (ctrl[3:2] == MODE_WDOG),
    .state    (state),
    .arm_done (arm_done),
    .svc_done (svc_done),
    .bad_key  (bad_key)
  );

  kwd_cfg #(.HW(HW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .wr_prd   ({wr_prd_hi, wr_prd_lo}),
    .wr_run   (wr_run),
    .wr_ctrl  (wr_ctrl),
    .wdata    (bus_wdata),
    .period   (period),
    .run_mode (run_mode),
    .ctrl     (ctrl)
  );

  kwd_count #(.HW(HW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (arm_done || svc_done || fire),
    .live     (live),
    .load_ok  (!locked),
    .wr_half  ({wr_cnt_hi, wr_cnt_lo}),
    .wdata    (bus_wdata),
    .gen_run  (gen_run),
    .run_mode (run_mode),
    .period   (period),
    .count    (count),
    .reached  (reached)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q     <= 1'b0;
      wdog_rst_o <= 1'b0;
    end else begin
      wdog_rst_o <= fire;
      if (fire)                                   flag_q <= 1'b1;
      else if (wr_wdog && flag_clr_of(bus_wdata)) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_ID):     bus_rdata = ID_VALUE;
      AW'(OFS_CNT_LO): bus_rdata = count[HW-1:0];
      AW'(OFS_CNT_HI): bus_rdata = count[CW-1:HW];
      AW'(OFS_PRD_LO): bus_rdata = period[HW-1:0];
      AW'(OFS_PRD_HI): bus_rdata = period[CW-1:HW];
      AW'(OFS_RUN):    bus_rdata = {24'h0, run_mode, 6'h0};
      AW'(OFS_CTRL):   bus_rdata = {28'h0, ctrl};
      AW'(OFS_WDOG):   bus_rdata = wdog_word(flag_q, locked);
      default:         bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wdog_rst_o,
  input logic          flag_q,
  input logic          live,
  input logic          locked,
  input logic          arm_done,
  input logic          svc_done,
  input logic [3:0]    ctrl,
  input logic          wr_prd_any,
  input logic [CW-1:0] period,
  input logic [CW-1:0] count
);
  assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> flag_q);

  assert_pulse_only_when_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> $past(live));

  assert_live_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> live);

  assert_period_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_prd_any) |=> $stable(period));

  assert_service_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (count == '0));

  assert_arm_in_wdog_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_done |-> (ctrl[3:2] == 2'd2));

  assert_arm_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_done |=> (count == '0) && live);
endmodule

bind keyed_wdog_timer kwd_checker #(.CW(CW)) i_kwd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wdog_rst_o (wdog_rst_o),
  .flag_q     (flag_q),
  .live       (live),
  .locked     (locked),
  .arm_done   (arm_done),
  .svc_done   (svc_done),
  .ctrl       (ctrl),
  .wr_prd_any (wr_prd_any),
  .period     (period),
  .count      (count)
);

// File: tb/test_keyed_wdog_timer.sv
module test_keyed_wdog_timer;
  localparam int AW = 6;
  localparam logic [31:0] ID = 32'h4B57_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wdog_rst_o;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog_timer #(.AW(AW), .ID_VALUE(ID)) i_keyed_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_o(wdog_rst_o)
  );

  always @(negedge clk) if (rst_n && wdog_rst_o) pulses++;

  function automatic logic [31:0] key_word(input logic [15:0] k, input logic en);
    return {k, 1'b0, en, 14'h0};
  endfunction
  function automatic logic [31:0] run_view(input logic [31:0] w);
    return w & 32'h0000_00C0;
  endfunction
  function automatic logic [31:0] ctrl_view(input logic [31:0] w);
    return w & 32'h0000_000F;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a[AW-1:0];
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[AW-1:0];
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2, r;
    int n;
    int snap;
    r = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, v); chk("R1 cnt_lo", v, 0);
    rd(8'h18, v); chk("R1 prd_lo", v, 0);
    rd(8'h24, v); chk("R1 ctrl", v, 0);
    rd(8'h28, v); chk("R1 wdog", v, 0);
    chk("R1 rst_out", {31'h0, wdog_rst_o}, 0);
    // R2 identification and unused offsets
    rd(8'h00, v); chk("R2 id", v, ID);
    rd(8'h04, v); chk("R2 unused 04", v, 0);
    rd(8'h2C, v); chk("R2 unused 2C", v, 0);

    // R2 random readback
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d0, d1, d2, d3, d4;
      d0 = $urandom; d1 = $urandom; d2 = $urandom; d3 = $urandom;
      wr(8'h24, 32'h0);
      wr(8'h18, d0); wr(8'h1C, d1); wr(8'h10, d2); wr(8'h14, d3);
      rd(8'h18, v); chk("R2 prd_lo", v, d0);
      rd(8'h1C, v); chk("R2 prd_hi", v, d1);
      rd(8'h10, v); chk("R2 cnt_lo", v, d2);
      rd(8'h14, v); chk("R2 cnt_hi", v, d3);
      d4 = $urandom;
      wr(8'h20, d4); rd(8'h20, v); chk("R2 run", v, run_view(d4));
      wr(8'h20, 32'h0);
      d4 = $urandom;
      wr(8'h24, d4); rd(8'h24, v); chk("R2 ctrl", v, ctrl_view(d4));
    end

    // R3 general timer, wrap mode
    wr(8'h24, 32'h0); wr(8'h20, 32'h0);
    wr(8'h18, 32'd10); wr(8'h1C, 32'h0); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
    wr(8'h24, 32'h3);
    wr(8'h20, 32'h80);
    repeat (10) @(negedge clk);
    rd(8'h10, v); chk("R3 wrap at period", v, 10);
    @(negedge clk);
    rd(8'h10, v); chk("R3 wrap to zero", v, 0);
    wr(8'h20, 32'h0);
    rd(8'h10, v);
    repeat (5) @(negedge clk);
    rd(8'h10, v2); chk("R3 mode0 holds", v2, v);
    // R3 one-shot
    wr(8'h10, 32'h0);
    wr(8'h20, 32'h40);
    repeat (15) @(negedge clk);
    rd(8'h10, v); chk("R3 once stops", v, 10);
    wr(8'h20, 32'h0);
    chk("R3 no pulse disarmed", pulses, 0);

    // R4 arm refused without enable or without watchdog mode
    wr(8'h28, key_word(16'hA5C6, 1'b1));
    rd(8'h28, v); chk("R4 key1 needs mode", v, 0);
    wr(8'h18, 32'd20); rd(8'h18, v); chk("R4 still writable", v, 20);
    wr(8'h24, 32'hB);
    wr(8'h28, key_word(16'hA5C6, 1'b0));
    rd(8'h28, v); chk("R4 key1 needs enable", v, 0);

    // R5 / R6 / R7 pre-active then wrong key
    wr(8'h28, key_word(16'hA5C6, 1'b1));
    rd(8'h28, v); chk("R5 enable reads 1", v, 32'h4000);
    wr(8'h18, 32'd99); rd(8'h18, v); chk("R6 prd locked", v, 20);
    wr(8'h28, key_word(16'h1234, 1'b1));
    rd(8'h28, v); chk("R7 wrong key disarms", v, 0);
    wr(8'h18, 32'd30); rd(8'h18, v); chk("R7 unlocked", v, 30);
    wr(8'h28, key_word(16'hA5C6, 1'b1));
    wr(8'h28, key_word(16'hDA7E, 1'b0));
    rd(8'h28, v); chk("R7 key2 no enable disarms", v, 0);

    // R4 / R8 arm and time out
    wr(8'h28, key_word(16'hA5C6, 1'b1));
    wr(8'h28, key_word(16'hDA7E, 1'b1));
    rd(8'h10, v); chk("R4 arm clears count", v, 0);
    n = 0;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      if (wdog_rst_o) begin n = k; break; end
    end
    chk("R8 timeout cycle", n, 31);
    rd(8'h28, v); chk("R8 flag set", v, 32'hC000);
    @(negedge clk);
    chk("R8 one cycle pulse", {31'h0, wdog_rst_o}, 0);

    // R11 / R5 flag clear, enable cannot be cleared
    wr(8'h28, 32'h0000_8000);
    rd(8'h28, v); chk("R11 flag cleared", v, 32'h4000);

    // R9 / R6 / R11 service with random protected writes
    snap = pulses;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      case ($urandom % 5)
        0: a = 8'h14; 1: a = 8'h18; 2: a = 8'h1C; 3: a = 8'h20; default: a = 8'h24;
      endcase
      wr(a, $urandom);
      repeat (5 + ($urandom % 15)) @(negedge clk);
      wr(8'h28, key_word(16'hA5C6, 1'b0));
      wr(8'h28, 32'h0000_8000);
      wr(8'h28, key_word(16'hDA7E, 1'b0));
      rd(8'h10, v); chk("R9 service restarts", v, 0);
    end
    chk("R9 no pulse on service", pulses, snap);
    rd(8'h18, v); chk("R6 prd_lo kept", v, 30);
    rd(8'h1C, v); chk("R6 prd_hi kept", v, 0);
    rd(8'h20, v); chk("R6 run kept", v, 0);
    rd(8'h24, v); chk("R6 ctrl kept", v, 32'hB);
    rd(8'h14, v); chk("R6 cnt_hi kept", v, 0);

    // R10 bad keys while armed
    wr(8'h28, key_word(16'hA5C6, 1'b0));
    wr(8'h28, key_word(16'h5555, 1'b0));
    chk("R10 bad key pulse", {31'h0, wdog_rst_o}, 1);
    rd(8'h28, v); chk("R10 flag", v, 32'hC000);
    rd(8'h10, v); chk("R10 count restart", v, 0);
    @(negedge clk);
    wr(8'h28, key_word(16'hDA7E, 1'b0));
    chk("R10 key2 alone pulse", {31'h0, wdog_rst_o}, 1);

    // R12 system reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h28, v); chk("R12 disarmed", v, 0);
    rd(8'h18, v); chk("R12 prd cleared", v, 0);
    chk("R12 rst_out low", {31'h0, wdog_rst_o}, 0);

    finish_run();
  end
endmodule